// File: doc/BRIEF.md
# Link Power Status Monitor

This block sits between a PHY core and its link-layer controller. It watches a power status input from the link and times how long that input stays inactive. A short loss is treated as a hiccup of the link side: the PHY-to-link interface receives a one-cycle reset pulse when the status returns. A long loss means the link has gone to sleep, so the interface enable is dropped to save power. The node's repeater function is not touched by any of this, and the block has no output that gates repeating.

While the interface is disabled, a strobe from the packet receiver reporting a link-on packet arms a wake-up clock. This clock is the system clock divided by a parameter, and it gives the sleeping link something to power itself up from. When the status input comes back, the interface is enabled again. The wake clock keeps running until software sets the link-control bit. The clock starts and stops only on its low phase, so it never emits a short pulse.

Both thresholds are parameters in clock cycles. The defaults of 59 and 1229 cycles correspond to about 1.2 µs and 25 µs at a 49.152 MHz clock. With the default divide-by-8, that same clock gives a wake frequency near 6.1 MHz.

Top module: `lpm_monitor`

## Requirements
- R1: After synchronous reset the interface enable is 1, the interface reset pulse is 0, the wake clock is 0 and the state code is 0.
- R2: A run of inactive (low) status samples no longer than SHORT_CYC (59) cycles is ignored. No reset pulse follows, and the enable stays 1.
- R3: When the status returns high after a low run longer than SHORT_CYC and shorter than LONG_CYC (1229), the interface reset output is high for exactly one cycle. That cycle is the one following the first high sample.
- R4: A low run that reaches LONG_CYC samples clears the interface enable on the edge of the LONG_CYC-th low sample. The inactivity count saturates, so a run of any greater length still produces no reset pulse on return.
- R5: While the enable is 0, the first high status sample sets the enable back to 1 on that same edge.
- R6: A link-on strobe sampled while the enable is 0 starts the wake clock. The clock is low for the next WAKE_DIV/2 (4) cycles, then high for 4 cycles, and repeats with period WAKE_DIV (8).
- R7: A link-on strobe sampled while the enable is 1 is ignored. The wake clock stays 0.
- R8: A sampled link-control bit disarms the wake clock. The clock finishes its current period and stays low. Every high phase lasts exactly WAKE_DIV/2 cycles, and the link-control bit takes priority over a simultaneous link-on strobe.
- R9: The state output encodes 0 = enabled with status high, 1 = enabled while counting a low run, 2 = disabled, and 3 = disabled with the wake clock armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lps_i | input | 1 | Link power status, high = link powered |
| link_on_i | input | 1 | One-cycle strobe: link-on packet received |
| lctrl_i | input | 1 | Link-control register bit from software |
| if_rst_o | output | 1 | One-cycle PHY-to-link interface reset |
| if_en_o | output | 1 | PHY-to-link interface enable |
| wake_clk_o | output | 1 | Divided wake-up clock for the link |
| state_o | output | 2 | State code (see R9) |

## Verification
The hardest case to reach is the wake clock stopping in the middle of a period. This needs three steps in order. First, a low run of more than 1229 cycles puts the block to sleep. Next, a link-on strobe arms the clock. Then the status returns, and the link-control bit is raised at a chosen point inside a high phase. The bench drives this full sequence. It then tracks the length of every high phase and confirms that the output settles low and stays there. The window edges are covered by exact run lengths of 59, 60, 1228 and 1229 cycles, plus one run far longer than the threshold to expose any counter wrap.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        ST_UP   = 2'd0,
        ST_LOSS = 2'd1,
        ST_OFF  = 2'd2,
        ST_WAKE = 2'd3
    } lpm_state_e;

    typedef enum logic [1:0] {
        GAP_NONE   = 2'd0,
        GAP_GLITCH = 2'd1,
        GAP_SHORT  = 2'd2,
        GAP_LONG   = 2'd3
    } gap_kind_e;

    typedef struct packed {
        logic sleep_hit;   // low run reaches the long threshold this edge
        logic short_done;  // status back high after a short-window run
    } gap_evt_t;

    // Sort a finished low run of 'run' samples into its window.
    function automatic gap_kind_e classify_gap(int unsigned run,
                                               int unsigned short_lim,
                                               int unsigned long_lim);
        if (run == 0)
            return GAP_NONE;
        else if (run <= short_lim)
            return GAP_GLITCH;
        else if (run < long_lim)
            return GAP_SHORT;
        else
            return GAP_LONG;
    endfunction

    function automatic lpm_state_e encode_state(logic en, logic counting, logic armed);
        if (en)
            return counting ? ST_LOSS : ST_UP;
        else
            return armed ? ST_WAKE : ST_OFF;
    endfunction

endpackage

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer
    import lpm_pkg::*;
#(
    parameter int SHORT_CYC = 59,
    parameter int LONG_CYC  = 1229
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     lps_i,
    output gap_evt_t evt_o,
    output logic     counting_o
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] LONG_V = CNT_W'(LONG_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    gap_kind_e        kind;

    // Saturating count of consecutive low samples.
    always_comb begin
        if (lps_i)
            cnt_d = '0;
        else if (cnt_q == LONG_V)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign kind = classify_gap(32'(cnt_q), SHORT_CYC, LONG_CYC);

    always_comb begin
        evt_o.sleep_hit  = !lps_i && (cnt_d == LONG_V) && (cnt_q != LONG_V);
        evt_o.short_done = lps_i && (kind == GAP_SHORT);
    end

    assign counting_o = (cnt_q != '0);

endmodule

// File: rtl/lpm_if_ctrl.sv
module lpm_if_ctrl
    import lpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lps_i,
    input  gap_evt_t evt_i,
    output logic     if_en_o,
    output logic     if_rst_o
);
    logic en_q;
    logic en_d;
    logic rst_q;

    always_comb begin
        en_d = en_q;
        if (evt_i.sleep_hit)
            en_d = 1'b0;
        else if (lps_i)
            en_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b1;
            rst_q <= 1'b0;
        end else begin
            en_q  <= en_d;
            rst_q <= evt_i.short_done && en_q;
        end
    end

    assign if_en_o  = en_q;
    assign if_rst_o = rst_q;

endmodule

// File: rtl/lpm_wake_gen.sv
module lpm_wake_gen #(
    parameter int WAKE_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic if_en_i,
    input  logic link_on_i,
    input  logic lctrl_i,
    output logic armed_o,
    output logic wake_o
);
    localparam int DIV_W = (WAKE_DIV > 2) ? $clog2(WAKE_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST_V = DIV_W'(WAKE_DIV - 1);
    localparam logic [DIV_W-1:0] HALF_V = DIV_W'(WAKE_DIV / 2);

    logic             arm_q, arm_d;
    logic             run_q, run_d;
    logic [DIV_W-1:0] div_q, div_d;
    logic             wk_q;

    always_comb begin
        arm_d = arm_q;
        if (lctrl_i)
            arm_d = 1'b0;
        else if (link_on_i && !if_en_i)
            arm_d = 1'b1;
    end

    // Start only from idle (output low); stop only after the last
    // high-phase cycle, so the output ends on a full period.
    always_comb begin
        run_d = run_q;
        div_d = div_q;
        if (!run_q) begin
            div_d = '0;
            if (arm_d)
                run_d = 1'b1;
        end else if (div_q == LAST_V) begin
            div_d = '0;
            if (!arm_d)
                run_d = 1'b0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            run_q <= 1'b0;
            div_q <= '0;
            wk_q  <= 1'b0;
        end else begin
            arm_q <= arm_d;
            run_q <= run_d;
            div_q <= div_d;
            wk_q  <= run_d && (div_d >= HALF_V);
        end
    end

    assign armed_o = arm_q;
    assign wake_o  = wk_q;

endmodule

// File: rtl/lpm_monitor.sv
module lpm_monitor
    import lpm_pkg::*;
#(
    parameter int SHORT_CYC = 59,
    parameter int LONG_CYC  = 1229,
    parameter int WAKE_DIV  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lps_i,
    input  logic       link_on_i,
    input  logic       lctrl_i,
    output logic       if_rst_o,
    output logic       if_en_o,
    output logic       wake_clk_o,
    output logic [1:0] state_o
);
    gap_evt_t   evt;
    logic       counting;
    logic       armed;
    lpm_state_e st;

    lpm_idle_timer #(
        .SHORT_CYC(SHORT_CYC),
        .LONG_CYC (LONG_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .lps_i     (lps_i),
        .evt_o     (evt),
        .counting_o(counting)
    );

    lpm_if_ctrl u_ifc (
        .clk     (clk),
        .rst     (rst),
        .lps_i   (lps_i),
        .evt_i   (evt),
        .if_en_o (if_en_o),
        .if_rst_o(if_rst_o)
    );

    lpm_wake_gen #(
        .WAKE_DIV(WAKE_DIV)
    ) u_wake (
        .clk      (clk),
        .rst      (rst),
        .if_en_i  (if_en_o),
        .link_on_i(link_on_i),
        .lctrl_i  (lctrl_i),
        .armed_o  (armed),
        .wake_o   (wake_clk_o)
    );

    assign st      = encode_state(if_en_o, counting, armed);
    assign state_o = st;

endmodule

// File: rtl/lpm_monitor_chk.sv
module lpm_monitor_chk #(
    parameter int WAKE_DIV = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       lps_i,
    input logic       if_rst_o,
    input logic       if_en_o,
    input logic       wake_clk_o,
    input logic [1:0] state_o
);
    localparam int HALF = WAKE_DIV / 2;

    int unsigned hi_run;

    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= 0;
        else if (wake_clk_o)
            hi_run <= hi_run + 1;
        else
            hi_run <= 0;
    end

    AST_RST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        if_rst_o |=> !if_rst_o); // R3

    AST_RST_AFTER_RETURN: assert property (@(posedge clk) disable iff (rst)
        if_rst_o |-> ($past(lps_i) && $past(if_en_o))); // R3

    AST_EN_DROP_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(if_en_o) |-> !$past(lps_i)); // R4

    AST_NO_RST_WHILE_OFF: assert property (@(posedge clk) disable iff (rst)
        !if_en_o |-> !if_rst_o); // R4

    AST_EN_RISE_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(if_en_o) |-> $past(lps_i)); // R5

    AST_WAKE_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(wake_clk_o) |-> (hi_run == HALF)); // R8

    AST_STATE_TRACKS_EN: assert property (@(posedge clk) disable iff (rst)
        state_o[1] == !if_en_o); // R9

endmodule

bind lpm_monitor lpm_monitor_chk #(.WAKE_DIV(WAKE_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lps_i     (lps_i),
    .if_rst_o  (if_rst_o),
    .if_en_o   (if_en_o),
    .wake_clk_o(wake_clk_o),
    .state_o   (state_o)
);

// File: tb/tb_lpm_monitor.sv
`timescale 1ns/1ps
module tb_lpm_monitor;
    localparam int SHORT = 59;
    localparam int LONG  = 1229;
    localparam int DIV   = 8;
    localparam int HALF  = DIV / 2;

    logic clk = 1'b0;
    logic rst, lps, lon, lctrl;
    logic if_rst, if_en, wake;
    logic [1:0] state;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    lpm_monitor #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .WAKE_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .lps_i(lps), .link_on_i(lon), .lctrl_i(lctrl),
        .if_rst_o(if_rst), .if_en_o(if_en), .wake_clk_o(wake), .state_o(state)
    );

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; lps = 1'b1; lon = 1'b0; lctrl = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // n low samples; afterwards lps is set high at a negedge
    task automatic low_run(int n);
        lps = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 en", if_en, 1);
        check("R1 rst", if_rst, 0);
        check("R1 wake", wake, 0);
        check("R1 state", state, 0);
    endtask

    task automatic t_glitch(int n);
        int pulses = 0;
        low_run(n);
        check("R9 state loss", state, 1);
        lps = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (if_rst) pulses++;
        end
        check("R2 no pulse", pulses, 0);
        check("R2 en kept", if_en, 1);
        check("R9 state up", state, 0);
    endtask

    task automatic t_short(int n);
        int pulses = 0;
        low_run(n);
        check("R3 en during", if_en, 1);
        lps = 1'b1;
        @(negedge clk);
        check("R3 pulse cycle", if_rst, 1);
        repeat (4) begin
            @(negedge clk);
            if (if_rst) pulses++;
        end
        check("R3 single pulse", pulses, 0);
    endtask

    task automatic t_long(int n);
        int pulses = 0;
        low_run(LONG - 1);
        check("R4 en before threshold", if_en, 1);
        low_run(1);
        check("R4 en dropped", if_en, 0);
        check("R9 state off", state, 2);
        if (n > LONG) low_run(n - LONG);
        lps = 1'b1;
        @(negedge clk);
        check("R5 re-enable", if_en, 1);
        if (if_rst) pulses++;
        repeat (4) begin
            @(negedge clk);
            if (if_rst) pulses++;
        end
        check("R4 no pulse after long run", pulses, 0);
    endtask

    task automatic t_lon_enabled();
        int highs = 0;
        lon = 1'b1;
        @(negedge clk);
        lon = 1'b0;
        repeat (3 * DIV) begin
            @(negedge clk);
            if (wake) highs++;
        end
        check("R7 wake idle", highs, 0);
        check("R7 state", state, 0);
    endtask

    task automatic t_wake_cycle();
        int bad = 0;
        int hi = 0;
        int badhi = 0;
        int after = 0;
        low_run(LONG + 3);
        lon = 1'b1;
        @(negedge clk);
        lon = 1'b0;
        check("R9 state wake", state, 3);
        check("R6 first cycle low", wake, 0);
        for (int i = 1; i < 2 * DIV; i++) begin
            @(negedge clk);
            if (wake !== (((i % DIV) >= HALF) ? 1'b1 : 1'b0)) bad++;
        end
        check("R6 waveform", bad, 0);
        lps = 1'b1;
        @(negedge clk);
        check("R5 en with wake", if_en, 1);
        // raise the control bit inside a high phase
        while (!wake) @(negedge clk);
        @(negedge clk);
        hi = 2;
        lctrl = 1'b1; lon = 1'b1;
        @(negedge clk);
        lctrl = 1'b0; lon = 1'b0;
        for (int i = 0; i < 3 * DIV; i++) begin
            if (wake) hi++;
            else begin
                if (hi != 0 && hi != HALF) badhi++;
                hi = 0;
            end
            @(negedge clk);
        end
        check("R8 high width", badhi, 0);
        repeat (2 * DIV) begin
            @(negedge clk);
            if (wake) after++;
        end
        check("R8 stopped", after, 0);
        check("R8 ends low", wake, 0);
    endtask

    initial begin
        t_reset();
        t_glitch(1);
        t_glitch(SHORT);
        t_short(SHORT + 1);
        t_short(LONG - 1);
        t_long(LONG);
        t_long(3 * LONG);
        t_lon_enabled();
        t_wake_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule